// File: doc/BRIEF.md
# Banked GPIO Interrupt Detector

This block watches 24 general-purpose input lines and turns configured pin conditions into one interrupt request. The lines are split into three banks of eight. Line n is handled by bank n/8 at bit n%8. Each pin is set up on its own as edge or level sensitive, with a chosen polarity. A both-edge option fires on any transition.

Pin inputs pass through a two-flop synchronizer. Edge events are held in a raw status register until they are cleared. Level conditions are tracked live while they last. A masked view combines raw status with a per-pin enable, and the OR of all masked bits drives a single registered interrupt output.

Configuration and status are reached over a byte-wide register bus. Each bus address holds one group and one bank: the group sits in address bits [4:2] and the bank in bits [1:0]. Writes take effect at the capturing clock edge. Read data is registered and follows the address by one cycle.

Top module: `gpio_irq_detect`

## Requirements
- R1: After synchronous reset, every configuration and status register reads 0 and `irq_out` is low.
- R2: Register address = {group[2:0], bank[1:0]}. The groups are: 0 both-edge, 1 polarity, 2 sense, 3 enable, 4 raw status (read only), 5 masked status (read only), 6 clear (write only, reads 0). Line n is bank n/8, bit n%8. Groups 0–3 read back what was written. A write to group 4 or 5 changes nothing.
- R3: A pin whose both-edge bit is 1 latches a raw status event on both rising and falling transitions, whatever its sense and polarity bits hold.
- R4: With both-edge 0 and sense 0 (edge mode), polarity 1 latches on a rising transition and polarity 0 latches on a falling transition. The opposite transition, or no transition, latches nothing. A latched bit stays set until it is cleared.
- R5: With both-edge 0 and sense 1 (level mode), the raw bit is 1 exactly while the synchronized pin equals the polarity bit. A clear write has no lasting effect on it, and it drops once the level goes inactive.
- R6: Masked status equals raw status AND enable. Clearing an enable bit hides the pin's status but keeps its configuration and its raw status.
- R7: Writing 1 to a bit of a bank's clear register clears that pin's latched edge event. Writing 0 has no effect. An edge event arriving at the same clock edge as its clear is kept.
- R8: `irq_out` is the registered OR of all masked status bits in all banks.
- R9: A pin change driven before clock edge k sets the raw bit at edge k+2 and raises `irq_out` at edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 24 | Asynchronous pin levels, line n at bit n |
| bus_addr | input | 5 | Register address {group, bank} |
| bus_we | input | 1 | Write strobe, captured at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the previous cycle's address |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Each result is due a fixed number of cycles after its stimulus:

- A register write is visible one edge after it is captured.
- Read data arrives one edge after the address is set.
- A pin change reaches raw status on the third edge and `irq_out` on the fourth.

The bench drives every input on the falling edge and samples on a later falling edge. It waits five cycles after any pin change before reading. The latency check samples `irq_out` after exactly three edges, expecting low, and after four, expecting high. The same-edge clear case places the clear write so that it is captured on the very edge that latches the event.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // Register groups, selected by address bits [4:2]
  typedef enum logic [2:0] {
    GRP_DUAL   = 3'd0,
    GRP_POL    = 3'd1,
    GRP_SENSE  = 3'd2,
    GRP_EN     = 3'd3,
    GRP_RAW    = 3'd4,
    GRP_MASKED = 3'd5,
    GRP_CLR    = 3'd6,
    GRP_NONE   = 3'd7
  } grp_e;

  localparam int GRP_LSB = 2;
  localparam int GRP_W   = 3;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 24,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] pin_s,
  input  logic              wr_hit,
  input  grp_e              wr_grp,
  input  logic [BANK_W-1:0] wr_data,
  output logic [BANK_W-1:0] dual_q,
  output logic [BANK_W-1:0] pol_q,
  output logic [BANK_W-1:0] sense_q,
  output logic [BANK_W-1:0] en_q,
  output logic [BANK_W-1:0] raw_q,
  output logic [BANK_W-1:0] masked
);
  logic [BANK_W-1:0] prev_q;
  logic [BANK_W-1:0] clr_vec, rise, fall, edge_evt, lvl_mask, lvl_on, raw_d;

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      dual_q  <= '0;
      pol_q   <= '0;
      sense_q <= '0;
      en_q    <= '0;
    end else if (wr_hit) begin
      case (wr_grp)
        GRP_DUAL:  dual_q  <= wr_data;
        GRP_POL:   pol_q   <= wr_data;
        GRP_SENSE: sense_q <= wr_data;
        GRP_EN:    en_q    <= wr_data;
        default: ;
      endcase
    end
  end

  // Event detection
  always_comb begin
    clr_vec  = (wr_hit && wr_grp == GRP_CLR) ? wr_data : '0;
    rise     = pin_s & ~prev_q;
    fall     = ~pin_s & prev_q;
    edge_evt = (dual_q & (rise | fall)) |
               (~dual_q & ~sense_q & ((pol_q & rise) | (~pol_q & fall)));
    lvl_mask = ~dual_q & sense_q;
    lvl_on   = ~(pin_s ^ pol_q);
    raw_d    = (lvl_mask & lvl_on) |
               (~lvl_mask & ((raw_q & ~clr_vec) | edge_evt));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      raw_q  <= '0;
    end else begin
      prev_q <= pin_s;
      raw_q  <= raw_d;
    end
  end

  assign masked = raw_q & en_q;

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1 |=> ((raw_q & $past(~dual_q & sense_q)) ==
           ($past(~(pin_s ^ pol_q)) & $past(~dual_q & sense_q)))); // R5
  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
    1 |=> ((raw_q & $past(raw_q & (dual_q | ~sense_q) & ~clr_vec)) ==
           $past(raw_q & (dual_q | ~sense_q) & ~clr_vec))); // R4
  AST_DUAL_CATCH: assert property (@(posedge clk) disable iff (rst)
    1 |=> ((raw_q & $past(dual_q & (pin_s ^ prev_q))) ==
           $past(dual_q & (pin_s ^ prev_q)))); // R3
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_BANKS   = 3,
  parameter int BANK_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_BANKS*BANK_W-1:0] pin_in,
  input  logic [GRP_LSB+GRP_W-1:0]    bus_addr,
  input  logic                        bus_we,
  input  logic [BANK_W-1:0]           bus_wdata,
  output logic [BANK_W-1:0]           bus_rdata,
  output logic                        irq_out
);
  localparam int NUM_PINS = NUM_BANKS * BANK_W;

  logic [NUM_PINS-1:0] pin_s;
  logic [GRP_LSB-1:0]  bank_idx;
  grp_e                grp;
  logic [BANK_W-1:0]   dual_a [NUM_BANKS];
  logic [BANK_W-1:0]   pol_a  [NUM_BANKS];
  logic [BANK_W-1:0]   sense_a[NUM_BANKS];
  logic [BANK_W-1:0]   en_a   [NUM_BANKS];
  logic [BANK_W-1:0]   raw_a  [NUM_BANKS];
  logic [BANK_W-1:0]   mask_a [NUM_BANKS];
  logic [NUM_PINS-1:0] en_flat, raw_flat, mask_flat;
  logic [BANK_W-1:0]   rd_word;
  logic [BANK_W-1:0]   rdata_q;
  logic                irq_q;

  assign bank_idx = bus_addr[GRP_LSB-1:0];
  assign grp      = grp_e'(bus_addr[GRP_LSB +: GRP_W]);

  gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = bus_we && (bank_idx == GRP_LSB'(b));
    gpio_irq_bank #(.BANK_W(BANK_W)) bank_i (
      .clk(clk), .rst(rst),
      .pin_s(pin_s[b*BANK_W +: BANK_W]),
      .wr_hit(hit), .wr_grp(grp), .wr_data(bus_wdata),
      .dual_q(dual_a[b]), .pol_q(pol_a[b]), .sense_q(sense_a[b]),
      .en_q(en_a[b]), .raw_q(raw_a[b]), .masked(mask_a[b])
    );
    assign en_flat[b*BANK_W +: BANK_W]   = en_a[b];
    assign raw_flat[b*BANK_W +: BANK_W]  = raw_a[b];
    assign mask_flat[b*BANK_W +: BANK_W] = mask_a[b];
  end

  // Read multiplexer
  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_idx == GRP_LSB'(b)) begin
        case (grp)
          GRP_DUAL:   rd_word = dual_a[b];
          GRP_POL:    rd_word = pol_a[b];
          GRP_SENSE:  rd_word = sense_a[b];
          GRP_EN:     rd_word = en_a[b];
          GRP_RAW:    rd_word = raw_a[b];
          GRP_MASKED: rd_word = mask_a[b];
          default:    rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= rd_word;
      irq_q   <= |mask_flat;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = irq_q;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!irq_out && bus_rdata == '0)); // R1
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    ($past(en_flat) == '0) |-> !irq_out); // R6
  AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(|(raw_flat & en_flat))); // R8
endmodule

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] pins = '0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_out;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_irq_detect dut_i (
    .clk(clk), .rst(rst), .pin_in(pins), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  typedef struct packed {
    logic [4:0] line;
    logic dual, sense, pol, v0, v1, expv;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{5'd0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    '{5'd1,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{5'd9,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{5'd10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{5'd17, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{5'd18, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    '{5'd23, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    '{5'd22, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{5'd8,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    '{5'd7,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{5'd16, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{5'd5,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  function automatic logic [4:0] ad(input int g, input int b);
    return {3'(g), 2'(b)};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic clear_all();
    for (int g = 0; g < 4; g++)
      for (int b = 0; b < 3; b++) wr(ad(g, b), 8'h00);
    for (int b = 0; b < 3; b++) wr(ad(6, b), 8'hFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq after reset", {7'd0, irq_out}, 8'h00);
    for (int g = 0; g < 7; g++)
      for (int b = 0; b < 3; b++) begin
        rd(ad(g, b), d);
        chk("R1 register after reset", d, 8'h00);
      end

    // R2 readback of configuration groups
    for (int g = 0; g < 4; g++)
      for (int b = 0; b < 3; b++) wr(ad(g, b), 8'((g * 3 + b + 1) * 8'h13));
    for (int g = 0; g < 4; g++)
      for (int b = 0; b < 3; b++) begin
        rd(ad(g, b), d);
        chk("R2 readback", d, 8'((g * 3 + b + 1) * 8'h13));
      end
    clear_all();
    wr(ad(4, 0), 8'hFF);
    wr(ad(5, 1), 8'hFF);
    rd(ad(4, 0), d); chk("R2 raw write ignored", d, 8'h00);
    rd(ad(5, 1), d); chk("R2 masked write ignored", d, 8'h00);
    rd(ad(6, 0), d); chk("R2 clear group reads 0", d, 8'h00);

    // Vector table: R3 R4 R5 R8
    foreach (VEC[i]) begin
      automatic int bk = VEC[i].line / 8;
      automatic int bt = VEC[i].line % 8;
      automatic logic [7:0] m = 8'(1 << bt);
      pins = '0;
      settle();
      clear_all();
      wr(ad(0, bk), VEC[i].dual  ? m : 8'h00);
      wr(ad(1, bk), VEC[i].pol   ? m : 8'h00);
      wr(ad(2, bk), VEC[i].sense ? m : 8'h00);
      wr(ad(3, bk), m);
      pins[VEC[i].line] = VEC[i].v0;
      settle();
      wr(ad(6, bk), 8'hFF);
      pins[VEC[i].line] = VEC[i].v1;
      settle();
      rd(ad(4, bk), d);
      chk("R3/R4/R5 raw bit", {7'd0, d[bt]}, {7'd0, VEC[i].expv});
      rd(ad(5, bk), d);
      chk("R6 masked bit", {7'd0, d[bt]}, {7'd0, VEC[i].expv});
      chk("R8 irq", {7'd0, irq_out}, {7'd0, VEC[i].expv});
    end

    // R6 masking keeps configuration and raw status
    pins = '0; settle(); clear_all();
    wr(ad(1, 0), 8'h08);
    pins[3] = 1'b1; settle();
    rd(ad(4, 0), d); chk("R6 raw while masked", d, 8'h08);
    rd(ad(5, 0), d); chk("R6 masked while disabled", d, 8'h00);
    chk("R6 irq while disabled", {7'd0, irq_out}, 8'h00);
    wr(ad(3, 0), 8'h08);
    rd(ad(5, 0), d); chk("R6 masked after enable", d, 8'h08);
    chk("R8 irq after enable", {7'd0, irq_out}, 8'h01);
    wr(ad(3, 0), 8'h00);
    rd(ad(1, 0), d); chk("R6 polarity kept", d, 8'h08);
    rd(ad(4, 0), d); chk("R6 raw kept", d, 8'h08);
    chk("R6 irq after disable", {7'd0, irq_out}, 8'h00);

    // R7 clear behaviour
    wr(ad(3, 0), 8'h08);
    wr(ad(6, 0), 8'h00);
    rd(ad(4, 0), d); chk("R7 zero clear no effect", d, 8'h08);
    chk("R7 irq after zero clear", {7'd0, irq_out}, 8'h01);
    wr(ad(6, 0), 8'h08);
    rd(ad(4, 0), d); chk("R7 clear by one", d, 8'h00);
    chk("R7 irq after clear", {7'd0, irq_out}, 8'h00);
    // event and clear captured at the same edge: falling, polarity 0
    wr(ad(1, 0), 8'h00);
    pins[3] = 1'b0;
    @(negedge clk); @(negedge clk);
    bus_addr = ad(6, 0); bus_wdata = 8'h08; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    rd(ad(4, 0), d); chk("R7 same-edge event kept", d, 8'h08);

    // R9 latency
    wr(ad(1, 0), 8'h08);
    settle();
    wr(ad(6, 0), 8'hFF);
    @(negedge clk);
    chk("R9 irq idle before edge", {7'd0, irq_out}, 8'h00);
    pins[3] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 irq low after three edges", {7'd0, irq_out}, 8'h00);
    @(negedge clk);
    chk("R9 irq high after four edges", {7'd0, irq_out}, 8'h01);

    // R5 level status survives clear, drops when inactive
    pins = '0; settle(); clear_all();
    wr(ad(1, 2), 8'h01); wr(ad(2, 2), 8'h01); wr(ad(3, 2), 8'h01);
    pins[16] = 1'b1; settle();
    wr(ad(6, 2), 8'hFF);
    rd(ad(4, 2), d); chk("R5 level survives clear", d, 8'h01);
    chk("R5 irq during level", {7'd0, irq_out}, 8'h01);
    pins[16] = 1'b0; settle();
    rd(ad(4, 2), d); chk("R5 level dropped", d, 8'h00);
    chk("R5 irq after level", {7'd0, irq_out}, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule